// File: doc/BRIEF.md
# Bidirectional Latch-Register Bus Transceiver

This block joins two data buses, A and B, through two independent one-way paths: A-to-B and B-to-A. Each path holds a storage register and a data selector. The path can pass its input straight through, hold a stored word, or load a new word when its strobe input falls. Each path has its own latch-enable, strobe and output-enable inputs. The two output enables have opposite polarity. The A-to-B enable turns on its drivers when high. The B-to-A enable turns on its drivers when low.

All logic runs on one system clock. The per-path strobes are ordinary inputs. The block samples them on each system clock edge and finds their falling edges by comparing each with its value from the previous cycle. The bus pins are split into three ports: data in, data out and a drive-enable output. A pad ring or the surrounding logic builds the real tristate. The data-out value stays valid while its drive-enable is off.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: The data width of each direction is the parameter `W`, which defaults to 18 bits.
- R2: When a path's latch-enable is high, its data output equals its data input in the same cycle (transparent).
- R3: When a path's latch-enable is low and its strobe has not fallen, its data output keeps its previous value, even if the input changes.
- R4: When a path's latch-enable is low and its strobe is sampled high in one cycle and low in the next, the path loads the input present in that second cycle. The data output shows the loaded word from the following cycle onward.
- R5: A rising strobe, or a strobe held high, with latch-enable low does not load the input.
- R6: A single strobe fall loads exactly once. While the strobe stays low afterwards, later input changes do not reach the output.
- R7: The A-to-B enable `ab_drive` is active high: `b_oe` is 1 when `ab_drive` is 1 and 0 when it is 0.
- R8: The B-to-A enable `ba_drive_n` is active low: `a_oe` is 1 when `ba_drive_n` is 0 and 0 when it is 1.
- R9: The two paths are independent. Activity on one path's inputs never changes the other path's outputs.
- R10: When latch-enable goes low while the strobe is low, the output keeps the value it had in the last transparent cycle.
- R11: A synchronous active-high `rst` clears both stored words to zero and the strobe history to low. The drive-enable outputs keep following their enable inputs during reset.
- R12: While a drive-enable output is 0, its data output still shows the transparent or stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Data sampled from bus A (A-to-B source) |
| a_out | output | W | Data for bus A from the B-to-A path |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | W | Data sampled from bus B (B-to-A source) |
| b_out | output | W | Data for bus B from the A-to-B path |
| b_oe | output | 1 | Drive enable for bus B |
| ab_latch_en | input | 1 | A-to-B transparent select (high = pass through) |
| ab_strobe | input | 1 | A-to-B strobe; a falling edge loads storage |
| ab_drive | input | 1 | A-to-B output enable, active high |
| ba_latch_en | input | 1 | B-to-A transparent select (high = pass through) |
| ba_strobe | input | 1 | B-to-A strobe; a falling edge loads storage |
| ba_drive_n | input | 1 | B-to-A output enable, active low |

## Verification
The assertions assume that the strobes and latch-enables are synchronous to the system clock and stable at each rising edge. They also assume that reset is held for at least two cycles at start-up, so the two-cycle look-back in the hold property sees only post-reset history. The stimulus changes every input only on the falling system-clock edge and keeps reset high for the first cycles. It moves each strobe level for at least one full cycle, so every strobe fall is sampled as a single-cycle event.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Storage takes a new word when transparent or when a strobe fall is seen.
  function automatic logic load_now(logic transparent, logic strobe_fell);
    return transparent | strobe_fell;
  endfunction

  // Output selector: the live input in transparent mode, otherwise the stored word.
  function automatic logic [63:0] pick_word(logic transparent, logic [63:0] live,
                                            logic [63:0] held);
    return transparent ? live : held;
  endfunction

  // Translate a raw enable pin into a drive strobe for a given polarity.
  function automatic logic drive_on(logic raw, bit active_low);
    return active_low ? ~raw : raw;
  endfunction

endpackage

// File: rtl/xcvr_fall_detect.sv
module xcvr_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic fell
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  assign fell = level_q & ~level;
endmodule

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         transparent,
  input  logic         strobe_fell,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int PadW = 64 - W;

  logic [W-1:0]  held_q;
  logic [63:0]   sel_wide;

  always_ff @(posedge clk) begin
    if (rst)                                 held_q <= '0;
    else if (load_now(transparent, strobe_fell)) held_q <= din;
  end

  assign sel_wide = pick_word(transparent, {{PadW{1'b0}}, din}, {{PadW{1'b0}}, held_q});
  assign dout     = sel_wide[W-1:0];
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W             = 18,
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         latch_en,
  input  logic         strobe,
  input  logic         enable_raw,
  output logic [W-1:0] dout,
  output logic         drive,
  output logic         capture
);
  xcvr_fall_detect u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (strobe),
    .fell  (capture)
  );

  xcvr_hold_reg #(.W(W)) u_store (
    .clk         (clk),
    .rst         (rst),
    .transparent (latch_en),
    .strobe_fell (capture),
    .din         (din),
    .dout        (dout)
  );

  generate
    if (OE_ACTIVE_LOW) begin : g_oe_low
      assign drive = drive_on(enable_raw, 1'b1);
    end else begin : g_oe_high
      assign drive = drive_on(enable_raw, 1'b0);
    end
  endgenerate
endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         ab_latch_en,
  input  logic         ab_strobe,
  input  logic         ab_drive,
  input  logic         ba_latch_en,
  input  logic         ba_strobe,
  input  logic         ba_drive_n
);
  // Load events of each path, named for the bound checker.
  logic ab_capture;
  logic ba_capture;

  xcvr_path #(.W(W), .OE_ACTIVE_LOW(1'b0)) u_ab (
    .clk        (clk),
    .rst        (rst),
    .din        (a_in),
    .latch_en   (ab_latch_en),
    .strobe     (ab_strobe),
    .enable_raw (ab_drive),
    .dout       (b_out),
    .drive      (b_oe),
    .capture    (ab_capture)
  );

  xcvr_path #(.W(W), .OE_ACTIVE_LOW(1'b1)) u_ba (
    .clk        (clk),
    .rst        (rst),
    .din        (b_in),
    .latch_en   (ba_latch_en),
    .strobe     (ba_strobe),
    .enable_raw (ba_drive_n),
    .dout       (a_out),
    .drive      (a_oe),
    .capture    (ba_capture)
  );
endmodule

// File: rtl/xcvr_path_chk.sv
module xcvr_path_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         le,
  input logic         strobe,
  input logic         capture,
  input logic [W-1:0] din,
  input logic [W-1:0] dout
);
  // R3: latched and no strobe fall seen in the previous cycle -> output holds
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!le && $past(!le) && $past(!rst) && ($past(strobe) == $past(strobe, 2)))
      |-> $stable(dout));

  // R4: strobe fall with latch-enable low loads the input of that cycle
  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (!le && $past(!rst) && $past(strobe) && !strobe)
      |=> (le || dout == $past(din)));

  // R6: a load event never repeats on consecutive cycles
  assert_single_load_R6: assert property (@(posedge clk) disable iff (rst)
    capture |=> !capture);

  // R10: leaving transparent mode keeps the last passed word
  assert_latch_close_R10: assert property (@(posedge clk) disable iff (rst)
    (!le && $past(le) && $past(!rst)) |-> dout == $past(din));

  // R11: right after reset the stored word is zero
  assert_reset_clear_R11: assert property (@(posedge clk)
    $past(rst) |-> (le || dout == '0));
endmodule

bind bidir_latch_xcvr xcvr_path_chk #(.W(W)) u_chk_ab (
  .clk(clk), .rst(rst), .le(ab_latch_en), .strobe(ab_strobe),
  .capture(ab_capture), .din(a_in), .dout(b_out));

bind bidir_latch_xcvr xcvr_path_chk #(.W(W)) u_chk_ba (
  .clk(clk), .rst(rst), .le(ba_latch_en), .strobe(ba_strobe),
  .capture(ba_capture), .din(b_in), .dout(a_out));

// File: tb/bidir_latch_xcvr_bench.sv
module bidir_latch_xcvr_bench;
  localparam int W = 18;

  typedef struct packed {
    logic [W-1:0] a_out;
    logic         a_oe;
    logic [W-1:0] b_out;
    logic         b_oe;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         ab_latch_en = 1'b0, ab_strobe = 1'b0, ab_drive = 1'b1;
  logic         ba_latch_en = 1'b0, ba_strobe = 1'b0, ba_drive_n = 1'b0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  // Next-step input shadows, written by the sequence and copied by the driver.
  logic         n_rst = 1'b1;
  logic [W-1:0] n_a = '0, n_b = '0;
  logic         n_ab_le = 1'b0, n_ab_st = 1'b0, n_ab_dr = 1'b1;
  logic         n_ba_le = 1'b0, n_ba_st = 1'b0, n_ba_drn = 1'b0;

  // Bench reference state.
  logic [W-1:0] m_ab_word = '0, m_ba_word = '0;
  logic         m_ab_prev = 1'b0, m_ba_prev = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    all_done = 1'b0;

  always #5 clk = ~clk;

  bidir_latch_xcvr #(.W(W)) u_bidir_latch_xcvr (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_latch_en(ab_latch_en), .ab_strobe(ab_strobe), .ab_drive(ab_drive),
    .ba_latch_en(ba_latch_en), .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n)
  );

  // Driver: apply one cycle of inputs, push its expected outputs, advance the model.
  task automatic step(input string tag);
    exp_t e;
    @(negedge clk);
    rst = n_rst; a_in = n_a; b_in = n_b;
    ab_latch_en = n_ab_le; ab_strobe = n_ab_st; ab_drive = n_ab_dr;
    ba_latch_en = n_ba_le; ba_strobe = n_ba_st; ba_drive_n = n_ba_drn;
    e.b_out = n_ab_le ? n_a : m_ab_word;
    e.b_oe  = (n_ab_dr == 1'b1);
    e.a_out = n_ba_le ? n_b : m_ba_word;
    e.a_oe  = (n_ba_drn == 1'b0);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (n_rst) begin
      m_ab_word = '0; m_ba_word = '0; m_ab_prev = 1'b0; m_ba_prev = 1'b0;
    end else begin
      if (n_ab_le || (m_ab_prev && !n_ab_st)) m_ab_word = n_a;
      if (n_ba_le || (m_ba_prev && !n_ba_st)) m_ba_word = n_b;
      m_ab_prev = n_ab_st;
      m_ba_prev = n_ba_st;
    end
  endtask

  // Monitor: compare outputs away from the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_vec++;
        if (a_out !== e.a_out || a_oe !== e.a_oe || b_out !== e.b_out || b_oe !== e.b_oe) begin
          n_bad++;
          $display("FAIL %s: got a_out=%h a_oe=%b b_out=%h b_oe=%b, expected a_out=%h a_oe=%b b_out=%h b_oe=%b",
                   t, a_out, a_oe, b_out, b_oe, e.a_out, e.a_oe, e.b_out, e.b_oe);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!all_done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: default width
    n_vec++;
    if ($bits(a_out) != 18 || $bits(b_out) != 18) begin
      n_bad++;
      $display("FAIL R1: got width %0d, expected 18", $bits(a_out));
    end

    // R11: reset clears storage, enables follow
    n_a = 18'h15A5A; n_b = 18'h0BEEF;
    step("R11 reset");
    step("R11 reset");
    n_ab_dr = 1'b0; n_ba_drn = 1'b1;
    step("R11 enables follow in reset");
    n_ab_dr = 1'b1; n_ba_drn = 1'b0;
    n_rst = 1'b0;
    step("R11 storage zero after reset");

    // R2: transparent on both paths
    n_ab_le = 1'b1; n_ba_le = 1'b1;
    n_a = 18'h00001; n_b = 18'h20000; step("R2 transparent");
    n_a = 18'h3FFFF; n_b = 18'h00000; step("R2 transparent");
    n_a = 18'h12345; n_b = 18'h2AAAA; step("R2 transparent");

    // R10: close latches while strobes low
    n_ab_le = 1'b0; n_ba_le = 1'b0;
    n_a = 18'h11111; n_b = 18'h22222; step("R10 close keeps last word");
    // R3: hold while inputs move
    n_a = 18'h33333; n_b = 18'h04444; step("R3 hold");
    n_a = 18'h05555; n_b = 18'h06666; step("R3 hold");

    // R5: rising strobe does not load
    n_ab_st = 1'b1; n_a = 18'h07777; step("R5 rising strobe no load");
    n_a = 18'h08888; step("R5 strobe high no load");
    n_a = 18'h09999; step("R3 hold with strobe high");

    // R4: falling strobe loads this cycle's input
    n_ab_st = 1'b0; n_a = 18'h0ABCD; step("R4 fall cycle shows old word");
    n_a = 18'h1F00F; step("R4 loaded word visible");

    // R6: no further loads while strobe stays low
    n_a = 18'h2E0E0; step("R6 single load");
    n_a = 18'h3D0D0; step("R6 single load");

    // R7 / R12: A-to-B disabled, data still visible
    n_ab_dr = 1'b0; step("R7 R12 b drivers off, data kept");
    n_ab_dr = 1'b1; step("R7 b drivers on");

    // R8 / R12: B-to-A disabled by high level
    n_ba_drn = 1'b1; step("R8 R12 a drivers off, data kept");
    n_ba_drn = 1'b0; step("R8 a drivers on");

    // R9: B-to-A load while A-to-B toggles transparent mode
    n_ba_st = 1'b1; n_ab_le = 1'b1; n_a = 18'h01010; step("R9 independence");
    n_ba_st = 1'b0; n_b = 18'h3C3C3; n_ab_le = 1'b0; n_a = 18'h02020; step("R9 ba load, ab close");
    n_b = 18'h00F0F; n_ab_st = 1'b1; step("R9 ba holds loaded word");
    n_ab_st = 1'b0; n_a = 18'h04040; step("R9 ab load, ba unaffected");
    n_a = 18'h05050; step("R9 both hold");

    // R4: strobe falls in the cycle latch-enable drops
    n_ab_le = 1'b1; n_ab_st = 1'b1; n_a = 18'h06060; step("R4 setup transparent");
    n_ab_le = 1'b0; n_ab_st = 1'b0; n_a = 18'h07070; step("R4 fall with close");
    n_a = 18'h08080; step("R4 loaded at close");

    // R11: reset mid-run, transparent path still passes input
    n_rst = 1'b1; n_ba_le = 1'b1; n_b = 18'h1ABCD; step("R11 mid-run reset");
    n_rst = 1'b0; n_ba_le = 1'b0; n_b = 18'h2DCBA; step("R11 cleared after reset");
    step("R11 cleared after reset");

    @(negedge clk);
    @(negedge clk);
    all_done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule